// File: doc/BRIEF.md
# Queued Multi-Core Memory Request Arbiter

This block lets several processor cores share a single memory request port. Every core pushes requests (a write-enable bit, an address and write data) into a small queue of its own, so a core waits only when that queue is full and never waits for a grant. Each clock the arbiter takes the head of at most one non-empty queue and moves it into a one-entry issue slot that drives the memory request channel with a valid/ready handshake. Each issued request carries a tag equal to the index of the core it came from.

Memory answers reads many cycles later, in issue order, and returns the tag alongside the read data. The arbiter raises the response valid bit of the tagged core only. A parameter picks the selection policy: fixed priority (lowest core index wins) or round robin (service rotates starting after the core last issued).

The issue slot is a two-state machine. `SLOT_EMPTY` means no request is offered; the LOAD transition to `SLOT_HELD` occurs when any queue is non-empty. In `SLOT_HELD` the request is offered; REFILL keeps the state while a handshake completes and another queue head is loaded, STALL keeps the state with the request frozen while memory is not ready, and DRAIN returns to `SLOT_EMPTY` when a handshake completes with all queues empty.

Top module: `mem_req_arbiter`

## Requirements
- R1: Each core owns a queue of QUEUE_DEPTH entries (default 4); `core_req_ready[i]` is low exactly when core i's queue holds QUEUE_DEPTH entries, a request is taken when valid and ready are both high, and a request offered while ready is low is dropped and never issued.
- R2: Requests from one core reach the memory channel in the order they were taken, with write-enable, address and write data unchanged; the request fields travel packed as {we, addr, wdata}.
- R3: At most one queue is popped per cycle, and while `mem_req_ready` stays high and requests wait, a handshake completes on every cycle.
- R4: When every queue is empty and no request is held, `mem_req_valid` is low.
- R5: With fixed priority, the issued request comes from the lowest-numbered non-empty queue.
- R6: With round robin, the next request comes from the first non-empty queue after the last issued core, wrapping from NUM_CORES-1 to 0; after reset core NUM_CORES-1 counts as last issued, so core 0 is served first.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the offered request (all fields and tag) stays unchanged, no queue is popped and the round-robin position does not move.
- R8: `mem_req_tag` equals the index of the core that supplied the offered request.
- R9: In the cycle `mem_rsp_valid` is high, only bit `mem_rsp_tag` of `core_rsp_valid` is set and `core_rsp_rdata` equals `mem_rsp_rdata`; with `mem_rsp_valid` low, `core_rsp_valid` is all zero.
- R10: After reset `mem_req_valid` is low, every queue is empty and every `core_req_ready` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | NUM_CORES | Per-core request valid |
| core_req_ready | output | NUM_CORES | Per-core queue has space |
| core_req_we | input | NUM_CORES | Per-core write enable |
| core_req_addr | input | NUM_CORES*ADDR_W | Per-core address, core i at bits [i*ADDR_W +: ADDR_W] |
| core_req_wdata | input | NUM_CORES*DATA_W | Per-core write data, core i at bits [i*DATA_W +: DATA_W] |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the offered request |
| mem_req_we | output | 1 | Offered request is a write |
| mem_req_addr | output | ADDR_W | Offered address |
| mem_req_wdata | output | DATA_W | Offered write data |
| mem_req_tag | output | TAG_W | Index of the issuing core |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_tag | input | TAG_W | Tag returned with the response |
| mem_rsp_rdata | input | DATA_W | Read data |
| core_rsp_valid | output | NUM_CORES | Response valid, one bit per core |
| core_rsp_rdata | output | DATA_W | Read data shared by all cores |

## Verification
The bench stalls memory while all four queues fill, then releases it and compares the issued tag order for both policies; a round-robin pointer that moved during the stall or started at the wrong core, or a fixed-priority mux that skipped a lower index, yields a wrong sequence. It fills one queue to its depth and offers one more request, so a queue that overwrote its oldest entry or accepted while full issues an extra or corrupted request on that core's stream. A long random run with random back-pressure tracks every core's stream in order and checks that a stalled request stays frozen, while reads return 20 or more cycles later so that a response steered to the wrong core or raised on two cores is caught.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        POLICY_FIXED = 1'b0,
        POLICY_RR    = 1'b1
    } policy_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/arb_req_queue.sv
module arb_req_queue #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 49
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (push && !pop)      count_q <= count_q + CNT_W'(1);
            else if (pop && !push) count_q <= count_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) store_q[wr_ptr_q] <= push_data;
    end

    always_comb begin
        head  = store_q[rd_ptr_q];
        full  = (int'(count_q) == DEPTH);
        empty = (count_q == '0);
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= DEPTH);

    // R1
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> int'(count_q) == int'($past(count_q)) + 1);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/arb_select.sv
module arb_select #(
    parameter int              NUM_CORES = 4,
    parameter int              TAG_W     = 2,
    parameter arb_pkg::policy_e POLICY   = arb_pkg::POLICY_RR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] req,
    input  logic                 advance,
    output logic [TAG_W-1:0]     grant_idx,
    output logic                 grant_any
);

    generate
        if (POLICY == arb_pkg::POLICY_FIXED) begin : g_fixed
            always_comb begin
                grant_idx = '0;
                for (int i = NUM_CORES - 1; i >= 0; i--) begin
                    if (req[i]) grant_idx = TAG_W'(i);
                end
                grant_any = |req;
            end

            // R5
            fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant_any |-> req[grant_idx] &&
                ((req & ((NUM_CORES'(1) << grant_idx) - NUM_CORES'(1))) == '0));

            logic unused_adv;
            assign unused_adv = advance;
        end else begin : g_rr
            logic [TAG_W-1:0] last_q;
            logic [TAG_W-1:0] cand;
            logic             found;

            always_ff @(posedge clk) begin
                if (!rst_n) last_q <= TAG_W'(NUM_CORES - 1);
                else if (advance) last_q <= grant_idx;
            end

            always_comb begin
                grant_idx = '0;
                found     = 1'b0;
                cand      = '0;
                for (int k = 0; k < NUM_CORES; k++) begin
                    cand = TAG_W'((int'(last_q) + 1 + k) % NUM_CORES);
                    if (!found && req[cand]) begin
                        found     = 1'b1;
                        grant_idx = cand;
                    end
                end
                grant_any = found;
            end

            // R6
            rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant_any && ($countones(req) > 1) |-> grant_idx != last_q);

            // R6
            rr_valid_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant_any |-> req[grant_idx]);
        end
    endgenerate

endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter #(
    parameter int               NUM_CORES   = 4,
    parameter int               QUEUE_DEPTH = 4,
    parameter int               ADDR_W      = 16,
    parameter int               DATA_W      = 32,
    parameter arb_pkg::policy_e POLICY      = arb_pkg::POLICY_RR,
    localparam int              TAG_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        core_req_valid,
    output logic [NUM_CORES-1:0]        core_req_ready,
    input  logic [NUM_CORES-1:0]        core_req_we,
    input  logic [NUM_CORES*ADDR_W-1:0] core_req_addr,
    input  logic [NUM_CORES*DATA_W-1:0] core_req_wdata,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic                        mem_req_we,
    output logic [ADDR_W-1:0]           mem_req_addr,
    output logic [DATA_W-1:0]           mem_req_wdata,
    output logic [TAG_W-1:0]            mem_req_tag,
    input  logic                        mem_rsp_valid,
    input  logic [TAG_W-1:0]            mem_rsp_tag,
    input  logic [DATA_W-1:0]           mem_rsp_rdata,
    output logic [NUM_CORES-1:0]        core_rsp_valid,
    output logic [DATA_W-1:0]           core_rsp_rdata
);
    import arb_pkg::*;

    localparam int ENT_W = 1 + ADDR_W + DATA_W;

    logic [ENT_W-1:0]     q_head [NUM_CORES];
    logic [NUM_CORES-1:0] q_full;
    logic [NUM_CORES-1:0] q_empty;
    logic [NUM_CORES-1:0] q_push;
    logic [NUM_CORES-1:0] q_pop;
    logic [NUM_CORES-1:0] nonempty;

    logic [TAG_W-1:0] grant_idx;
    logic             grant_any;
    logic             load_ok;
    logic             advance;

    slot_state_e      state_q, state_nx;
    logic [ENT_W-1:0] slot_q;
    logic [TAG_W-1:0] slot_tag_q;

    // per-core queues
    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            assign q_push[c]   = core_req_valid[c] && !q_full[c];
            assign q_pop[c]    = advance && (grant_idx == TAG_W'(c));
            assign nonempty[c] = !q_empty[c];
            assign core_req_ready[c] = !q_full[c];

            arb_req_queue #(
                .DEPTH (QUEUE_DEPTH),
                .WIDTH (ENT_W)
            ) u_queue (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (q_push[c]),
                .push_data ({core_req_we[c],
                             core_req_addr[c*ADDR_W +: ADDR_W],
                             core_req_wdata[c*DATA_W +: DATA_W]}),
                .pop       (q_pop[c]),
                .head      (q_head[c]),
                .full      (q_full[c]),
                .empty     (q_empty[c])
            );
        end
    endgenerate

    arb_select #(
        .NUM_CORES (NUM_CORES),
        .TAG_W     (TAG_W),
        .POLICY    (POLICY)
    ) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (nonempty),
        .advance   (advance),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    assign load_ok = (state_q == SLOT_EMPTY) || mem_req_ready;
    assign advance = load_ok && grant_any;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q     <= '0;
            slot_tag_q <= '0;
        end else if (advance) begin
            slot_q     <= q_head[grant_idx];
            slot_tag_q <= grant_idx;
        end
    end

    // transitions: LOAD, REFILL, STALL, DRAIN
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (grant_any) state_nx = SLOT_HELD;
            SLOT_HELD:  if (mem_req_ready && !grant_any) state_nx = SLOT_EMPTY;
            default:    state_nx = SLOT_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = (state_q == SLOT_HELD);
        {mem_req_we, mem_req_addr, mem_req_wdata} = slot_q;
        mem_req_tag   = slot_tag_q;
        core_rsp_rdata = mem_rsp_rdata;
        for (int i = 0; i < NUM_CORES; i++) begin
            core_rsp_valid[i] = mem_rsp_valid && (mem_rsp_tag == TAG_W'(i));
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
        $stable(mem_req_wdata) && $stable(mem_req_we) && $stable(mem_req_tag));

    // R7
    stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |-> q_pop == '0);

    // R3
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_pop));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_valid || mem_req_ready) && (nonempty == '0) |=> !mem_req_valid);

    // R8
    tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> int'(mem_req_tag) < NUM_CORES);

    // R9
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_rsp_valid) && (mem_rsp_valid || core_rsp_valid == '0));

endmodule

// File: tb/mem_req_arbiter_test.sv
`timescale 1ns/1ps
module mem_req_arbiter_test;
    localparam int N = 4;
    localparam int A = 16;
    localparam int D = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]   core_valid = '0;
    logic [N-1:0]   fp_valid = '0;
    logic [N-1:0]   core_we = '0;
    logic [N*A-1:0] core_addr = '0;
    logic [N*D-1:0] core_wdata = '0;
    logic           mem_ready = 1'b0;
    logic           rsp_valid = 1'b0;
    logic           fp_rsp_valid = 1'b0;
    logic [1:0]     rsp_tag = '0;
    logic [D-1:0]   rsp_data = '0;

    logic [N-1:0] core_ready, fp_ready;
    logic         mreq_valid, fp_mvalid;
    logic         mreq_we, fp_we;
    logic [A-1:0] mreq_addr, fp_addr;
    logic [D-1:0] mreq_wdata, fp_wdata;
    logic [1:0]   mreq_tag, fp_tag;
    logic [N-1:0] crsp_valid, fp_crsp_valid;
    logic [D-1:0] crsp_data, fp_crsp_data;

    mem_req_arbiter #(.NUM_CORES(N), .QUEUE_DEPTH(4), .ADDR_W(A), .DATA_W(D),
                      .POLICY(arb_pkg::POLICY_RR)) uut (
        .clk(clk), .rst_n(rst_n),
        .core_req_valid(core_valid), .core_req_ready(core_ready),
        .core_req_we(core_we), .core_req_addr(core_addr), .core_req_wdata(core_wdata),
        .mem_req_valid(mreq_valid), .mem_req_ready(mem_ready), .mem_req_we(mreq_we),
        .mem_req_addr(mreq_addr), .mem_req_wdata(mreq_wdata), .mem_req_tag(mreq_tag),
        .mem_rsp_valid(rsp_valid), .mem_rsp_tag(rsp_tag), .mem_rsp_rdata(rsp_data),
        .core_rsp_valid(crsp_valid), .core_rsp_rdata(crsp_data));

    mem_req_arbiter #(.NUM_CORES(N), .QUEUE_DEPTH(4), .ADDR_W(A), .DATA_W(D),
                      .POLICY(arb_pkg::POLICY_FIXED)) uut_fp (
        .clk(clk), .rst_n(rst_n),
        .core_req_valid(fp_valid), .core_req_ready(fp_ready),
        .core_req_we(core_we), .core_req_addr(core_addr), .core_req_wdata(core_wdata),
        .mem_req_valid(fp_mvalid), .mem_req_ready(mem_ready), .mem_req_we(fp_we),
        .mem_req_addr(fp_addr), .mem_req_wdata(fp_wdata), .mem_req_tag(fp_tag),
        .mem_rsp_valid(fp_rsp_valid), .mem_rsp_tag(rsp_tag), .mem_rsp_rdata(rsp_data),
        .core_rsp_valid(fp_crsp_valid), .core_rsp_rdata(fp_crsp_data));

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    bit [48:0] exp_q [N][$];
    int        rsp_tag_q [$];
    bit [D-1:0] rsp_data_q [$];
    int        rsp_due_q [$];
    int        last_due = 0;
    int        rr_seq [$];
    int        fp_seq [$];

    bit        stall_seen = 1'b0;
    bit [50:0] stall_vals = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic bit [D-1:0] read_value(input bit [A-1:0] a);
        return {a, ~a};
    endfunction

    function automatic int rr_order(input int k);
        int s [10] = '{0, 1, 2, 3, 0, 1, 2, 3, 3, 3};
        return s[k];
    endfunction

    function automatic int fp_order(input int k);
        return k / 2;
    endfunction

    task automatic step();
        bit [48:0] want;
        int due;
        rsp_valid = 1'b0;
        if (rsp_due_q.size() > 0 && rsp_due_q[0] <= cyc) begin
            rsp_valid = 1'b1;
            rsp_tag   = 2'(rsp_tag_q.pop_front());
            rsp_data  = rsp_data_q.pop_front();
            void'(rsp_due_q.pop_front());
        end
        #1;
        if (rsp_valid) begin
            check(crsp_valid == (4'b0001 << rsp_tag), "R9 route", 64'(crsp_valid),
                  64'(4'b0001 << rsp_tag));
            check(crsp_data == rsp_data, "R9 data", 64'(crsp_data), 64'(rsp_data));
        end else if (crsp_valid != '0) begin
            check(1'b0, "R9 idle", 64'(crsp_valid), 64'd0);
        end
        if (stall_seen) begin
            check(mreq_valid && {mreq_we, mreq_addr, mreq_wdata, mreq_tag} == stall_vals,
                  "R7 hold", 64'({mreq_valid, mreq_addr, mreq_tag}),
                  64'({1'b1, stall_vals[33:18], stall_vals[1:0]}));
        end
        stall_seen = mreq_valid && !mem_ready;
        stall_vals = {mreq_we, mreq_addr, mreq_wdata, mreq_tag};
        if (mreq_valid && mem_ready) begin
            rr_seq.push_back(int'(mreq_tag));
            if (exp_q[mreq_tag].size() == 0) begin
                check(1'b0, "R2/R8 unexpected request", 64'(mreq_addr), 64'd0);
            end else begin
                want = exp_q[mreq_tag].pop_front();
                check({mreq_we, mreq_addr, mreq_wdata} == want, "R2/R8 stream",
                      64'({mreq_we, mreq_addr, mreq_wdata}), 64'(want));
            end
            if (!mreq_we) begin
                due = cyc + 20 + int'($urandom % 8);
                if (due <= last_due) due = last_due + 1;
                last_due = due;
                rsp_due_q.push_back(due);
                rsp_tag_q.push_back(int'(mreq_tag));
                rsp_data_q.push_back(read_value(mreq_addr));
            end
        end
        if (fp_mvalid && mem_ready) fp_seq.push_back(int'(fp_tag));
        for (int i = 0; i < N; i++) begin
            if (core_valid[i] && core_ready[i])
                exp_q[i].push_back({core_we[i], core_addr[i*A +: A], core_wdata[i*D +: D]});
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic set_core(input int i, input bit we, input bit [A-1:0] a,
                            input bit [D-1:0] d);
        core_we[i] = we;
        core_addr[i*A +: A] = a;
        core_wdata[i*D +: D] = d;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        finish_run();
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!mreq_valid && !fp_mvalid, "R10 valid", 64'(mreq_valid), 64'd0);
        check(core_ready == '1 && fp_ready == '1, "R10 ready", 64'(core_ready), 64'hF);
        check(crsp_valid == '0, "R10 rsp", 64'(crsp_valid), 64'd0);

        // directed: fill every queue with memory stalled
        mem_ready = 1'b0;
        for (int k = 0; k < 2; k++) begin
            core_valid = '1;
            fp_valid   = '1;
            for (int i = 0; i < N; i++) set_core(i, 1'b0, A'(i * 16 + k), D'(32'hC0DE0000 + i * 16 + k));
            step();
        end
        core_valid = '0;
        fp_valid   = '0;
        step();
        step();
        // R6 core 0 first after reset; R5 lowest index wins
        check(mreq_valid && mreq_tag == 2'd0, "R6 first", 64'(mreq_tag), 64'd0);
        check(fp_mvalid && fp_tag == 2'd0, "R5 first", 64'(fp_tag), 64'd0);
        step();
        step();
        step();
        // R1 fill core 3 to its depth
        for (int k = 2; k < 4; k++) begin
            core_valid = 4'b1000;
            set_core(3, 1'b0, A'(48 + k), D'(32'hC0DE0030 + k));
            step();
        end
        check(core_ready[3] == 1'b0, "R1 full", 64'(core_ready[3]), 64'd0);
        check(core_ready[2:0] == 3'b111, "R1 others", 64'(core_ready[2:0]), 64'h7);
        set_core(3, 1'b0, A'(16'h3F), D'(32'hDEAD003F));
        step();
        core_valid = '0;
        rr_seq.delete();
        fp_seq.delete();
        mem_ready = 1'b1;
        for (int k = 0; k < 10; k++) step();
        // R3 back-to-back issue
        check(rr_seq.size() == 10, "R3 rr count", 64'(rr_seq.size()), 64'd10);
        check(fp_seq.size() == 8, "R3 fixed count", 64'(fp_seq.size()), 64'd8);
        for (int k = 0; k < 10 && k < rr_seq.size(); k++)
            check(rr_seq[k] == rr_order(k), "R6 order", 64'(rr_seq[k]), 64'(rr_order(k)));
        for (int k = 0; k < 8 && k < fp_seq.size(); k++)
            check(fp_seq[k] == fp_order(k), "R5 order", 64'(fp_seq[k]), 64'(fp_order(k)));
        // R4 idle after draining
        check(!mreq_valid && !fp_mvalid, "R4 idle", 64'({mreq_valid, fp_mvalid}), 64'd0);
        check(core_ready == '1, "R1 ready restored", 64'(core_ready), 64'hF);

        // random traffic with random back-pressure
        for (int t = 0; t < 3000; t++) begin
            for (int i = 0; i < N; i++) begin
                core_valid[i] = ($urandom % 10) < 4;
                set_core(i, 1'($urandom), A'($urandom), D'($urandom));
            end
            mem_ready = ($urandom % 10) < 7;
            step();
        end
        core_valid = '0;
        mem_ready  = 1'b1;
        for (int t = 0; t < 600; t++) begin
            if (rsp_due_q.size() == 0 && exp_q[0].size() == 0 && exp_q[1].size() == 0 &&
                exp_q[2].size() == 0 && exp_q[3].size() == 0 && t > 2) break;
            step();
        end
        for (int i = 0; i < N; i++)
            check(exp_q[i].size() == 0, "R2 drained", 64'(exp_q[i].size()), 64'd0);
        check(rsp_due_q.size() == 0, "R9 all returned", 64'(rsp_due_q.size()), 64'd0);
        check(!mreq_valid, "R4 final idle", 64'(mreq_valid), 64'd0);
        finish_run();
    end

endmodule